// File: doc/BRIEF.md
# Random Parent Fetch Sequencer

This block gathers a set of parent vectors for one generation of a real-valued evolutionary search. It receives `NUM_PAR` individual numbers at once, one for each parent slot. On a start pulse it reads every element of each chosen individual from a shared population memory and writes each element into the parent memory that belongs to that slot. The population memory holds each individual as `NUM_ELEM` consecutive words. Its address is therefore the individual number with the element number appended below it.

Two counters step through the copy. An element counter runs through the words of one individual. A slot counter picks both the individual number used for the read and the parent memory that receives the data, and it moves on only after an individual's last element. The population memory has a synchronous read, so the write strobe, write address and slot select are delayed one cycle to line up with the returning data. The controller has four states. IDLE waits for start (IDLE→FETCH on an accepted start). FETCH issues one read per cycle (FETCH→FLUSH after the final element of the final slot). FLUSH lets the last write land (FLUSH→FINISH unconditionally). FINISH raises done for one cycle (FINISH→IDLE unconditionally). Choosing the random numbers and keeping them distinct is left to the surrounding logic.

Top module: `parent_fetch_seq`

## Requirements
- R1: While reset is held and after its release, the block is idle: `busy_o`, `done_o`, `pop_rd_en_o` and every bit of `par_wr_en_o` are 0.
- R2: A start pulse sampled while idle begins a copy. `pop_rd_en_o` is then high for exactly `NUM_PAR*NUM_ELEM` consecutive cycles, starting the cycle after the start edge.
- R3: Each read address is the selected individual number in the upper `IDX_W` bits and the element number in the lower `ELEM_W` bits. Slot k's individual number is taken from `idx_i[k*IDX_W +: IDX_W]`.
- R4: Reads run through elements 0 to `NUM_ELEM-1` of slot 0, then of slot 1, and so on. The slot advances only after element `NUM_ELEM-1`.
- R5: Each read is followed one cycle later by a write of the returned word. Only bit k of `par_wr_en_o` is high, where k is the slot being read, and `par_wr_addr_o` holds the element number. No more than one write enable is ever high at a time.
- R6: The individual numbers are captured at the accepted start. Changes on `idx_i` during the copy do not alter which words are copied.
- R7: `done_o` is high for exactly one cycle, the cycle after the last write, which is `NUM_PAR*NUM_ELEM+2` cycles after the start edge. `busy_o` falls with it.
- R8: A start pulse while a copy is running is ignored. The copy's timing, write count and contents stay those of the original start.
- R9: After done the block is idle and accepts a new start. Repeated individual numbers are copied like any others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse |
| idx_i | input | NUM_PAR*IDX_W | Individual number for each slot, slot 0 in the low bits |
| pop_rd_en_o | output | 1 | Population memory read strobe |
| pop_rd_addr_o | output | IDX_W+ELEM_W | Population memory read address |
| pop_rd_data_i | input | DATA_W | Population read data, valid one cycle after the strobe |
| par_wr_en_o | output | NUM_PAR | One write strobe per parent memory |
| par_wr_addr_o | output | ELEM_W | Element address in the parent memory |
| par_wr_data_o | output | DATA_W | Word written to the parent memory |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench runs directed copies and seeded random copies. The directed cases include slot numbers at the extremes and all slots naming the same individual. The words it collects in its parent memory model expose a design that moves the slot one element early or late. They also expose a design that drops the read-to-write delay, since each word would then land one element off. For some copies the bench changes `idx_i` and pulses start in mid-copy, which catches a design that follows the live inputs or restarts its counters. It also counts cycles from start to done and checks that done lasts a single cycle, so a missing flush state or a done that stays high is reported.

// File: rtl/pf_pkg.sv
package pf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_FLUSH,
        ST_FINISH
    } pf_state_t;
endpackage

// File: rtl/pf_step_counter.sv
module pf_step_counter #(
    parameter int NUM_ELEM = 4,
    parameter int NUM_PAR  = 4,
    localparam int ELEM_W  = $clog2(NUM_ELEM),
    localparam int PAR_W   = $clog2(NUM_PAR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [ELEM_W-1:0] elem_o,
    output logic [PAR_W-1:0]  par_o,
    output logic              final_o
);
    localparam logic [ELEM_W-1:0] ELEM_MAX = ELEM_W'(NUM_ELEM - 1);
    localparam logic [PAR_W-1:0]  PAR_MAX  = PAR_W'(NUM_PAR - 1);

    logic [ELEM_W-1:0] elem_q;
    logic [PAR_W-1:0]  par_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            elem_q <= '0;
            par_q  <= '0;
        end else if (step) begin
            if (elem_q == ELEM_MAX) begin
                elem_q <= '0;
                par_q  <= par_q + 1'b1;
            end else begin
                elem_q <= elem_q + 1'b1;
            end
        end
    end

    assign elem_o  = elem_q;
    assign par_o   = par_q;
    assign final_o = (elem_q == ELEM_MAX) && (par_q == PAR_MAX);
endmodule

// File: rtl/pf_addr_build.sv
module pf_addr_build #(
    parameter int NUM_PAR = 4,
    parameter int IDX_W   = 5,
    parameter int ELEM_W  = 2,
    localparam int PAR_W  = $clog2(NUM_PAR)
) (
    input  logic [NUM_PAR*IDX_W-1:0] idx_flat,
    input  logic [PAR_W-1:0]         par_sel,
    input  logic [ELEM_W-1:0]        elem,
    output logic [IDX_W+ELEM_W-1:0]  addr
);
    logic [IDX_W-1:0] idx_arr [NUM_PAR];

    for (genvar g = 0; g < NUM_PAR; g++) begin : g_split
        assign idx_arr[g] = idx_flat[g*IDX_W +: IDX_W];
    end

    assign addr = {idx_arr[par_sel], elem};
endmodule

// File: rtl/pf_write_demux.sv
module pf_write_demux #(
    parameter int NUM_PAR = 4,
    parameter int ELEM_W  = 2,
    localparam int PAR_W  = $clog2(NUM_PAR)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_fire,
    input  logic [PAR_W-1:0]   par_sel,
    input  logic [ELEM_W-1:0]  elem,
    output logic [NUM_PAR-1:0] wr_en,
    output logic [ELEM_W-1:0]  wr_addr
);
    logic               fire_q;
    logic [PAR_W-1:0]   sel_q;
    logic [ELEM_W-1:0]  elem_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire_q <= 1'b0;
            sel_q  <= '0;
            elem_q <= '0;
        end else begin
            fire_q <= rd_fire;
            sel_q  <= par_sel;
            elem_q <= elem;
        end
    end

    for (genvar g = 0; g < NUM_PAR; g++) begin : g_strobe
        assign wr_en[g] = fire_q && (sel_q == PAR_W'(g));
    end

    assign wr_addr = elem_q;
endmodule

// File: rtl/parent_fetch_seq.sv
module parent_fetch_seq
    import pf_pkg::*;
#(
    parameter int NUM_PAR  = 4,
    parameter int NUM_ELEM = 4,
    parameter int IDX_W    = 5,
    parameter int DATA_W   = 32,
    localparam int ELEM_W  = $clog2(NUM_ELEM),
    localparam int PAR_W   = $clog2(NUM_PAR),
    localparam int ADDR_W  = IDX_W + ELEM_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [NUM_PAR*IDX_W-1:0] idx_i,
    output logic                     pop_rd_en_o,
    output logic [ADDR_W-1:0]        pop_rd_addr_o,
    input  logic [DATA_W-1:0]        pop_rd_data_i,
    output logic [NUM_PAR-1:0]       par_wr_en_o,
    output logic [ELEM_W-1:0]        par_wr_addr_o,
    output logic [DATA_W-1:0]        par_wr_data_o,
    output logic                     busy_o,
    output logic                     done_o
);
    pf_state_t state_q, state_d;

    logic                     accept;
    logic                     final_step;
    logic [ELEM_W-1:0]        elem_cnt;
    logic [PAR_W-1:0]         par_cnt;
    logic [NUM_PAR*IDX_W-1:0] idx_q;

    assign accept = (state_q == ST_IDLE) && start_i;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i)    state_d = ST_FETCH;
            ST_FETCH:  if (final_step) state_d = ST_FLUSH;
            ST_FLUSH:                  state_d = ST_FINISH;
            ST_FINISH:                 state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        pop_rd_en_o = 1'b0;
        busy_o      = 1'b1;
        done_o      = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy_o      = 1'b0;
            ST_FETCH:  pop_rd_en_o = 1'b1;
            ST_FLUSH:  ;
            ST_FINISH: done_o      = 1'b1;
            default:   busy_o      = 1'b0;
        endcase
    end

    // Index capture on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (accept) idx_q <= idx_i;
    end

    pf_step_counter #(
        .NUM_ELEM (NUM_ELEM),
        .NUM_PAR  (NUM_PAR)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .step    (pop_rd_en_o),
        .elem_o  (elem_cnt),
        .par_o   (par_cnt),
        .final_o (final_step)
    );

    pf_addr_build #(
        .NUM_PAR (NUM_PAR),
        .IDX_W   (IDX_W),
        .ELEM_W  (ELEM_W)
    ) u_addr (
        .idx_flat (idx_q),
        .par_sel  (par_cnt),
        .elem     (elem_cnt),
        .addr     (pop_rd_addr_o)
    );

    pf_write_demux #(
        .NUM_PAR (NUM_PAR),
        .ELEM_W  (ELEM_W)
    ) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_fire (pop_rd_en_o),
        .par_sel (par_cnt),
        .elem    (elem_cnt),
        .wr_en   (par_wr_en_o),
        .wr_addr (par_wr_addr_o)
    );

    assign par_wr_data_o = pop_rd_data_i;
endmodule

// File: rtl/pf_checker.sv
module pf_checker #(
    parameter int NUM_PAR  = 4,
    parameter int NUM_ELEM = 4,
    parameter int ELEM_W   = 2,
    parameter int ADDR_W   = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pop_rd_en_o,
    input logic [ADDR_W-1:0]  pop_rd_addr_o,
    input logic [NUM_PAR-1:0] par_wr_en_o,
    input logic               busy_o,
    input logic               done_o
);
    localparam logic [ELEM_W-1:0] EMAX = ELEM_W'(NUM_ELEM - 1);

    p_idle_no_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !pop_rd_en_o);

    p_elem_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_rd_en_o && $past(pop_rd_en_o) && ($past(pop_rd_addr_o[ELEM_W-1:0]) != EMAX))
        |-> (pop_rd_addr_o[ELEM_W-1:0] == $past(pop_rd_addr_o[ELEM_W-1:0]) + 1'b1)
         && (pop_rd_addr_o[ADDR_W-1:ELEM_W] == $past(pop_rd_addr_o[ADDR_W-1:ELEM_W])));

    p_elem_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_rd_en_o && $past(pop_rd_en_o) && ($past(pop_rd_addr_o[ELEM_W-1:0]) == EMAX))
        |-> (pop_rd_addr_o[ELEM_W-1:0] == '0));

    p_write_lags_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|par_wr_en_o) == $past(pop_rd_en_o));

    p_single_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(par_wr_en_o));

    p_done_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(|par_wr_en_o) && !pop_rd_en_o);
endmodule

bind parent_fetch_seq pf_checker #(
    .NUM_PAR  (NUM_PAR),
    .NUM_ELEM (NUM_ELEM),
    .ELEM_W   (ELEM_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pop_rd_en_o   (pop_rd_en_o),
    .pop_rd_addr_o (pop_rd_addr_o),
    .par_wr_en_o   (par_wr_en_o),
    .busy_o        (busy_o),
    .done_o        (done_o)
);

// File: tb/sim_parent_fetch_seq.sv
`timescale 1ns/1ps
module sim_parent_fetch_seq;
    localparam int NP = 4;
    localparam int NE = 4;
    localparam int IW = 5;
    localparam int DW = 32;
    localparam int EW = $clog2(NE);
    localparam int AW = IW + EW;
    localparam int T  = NP * NE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [NP*IW-1:0] idx_i = '0;
    logic          pop_rd_en_o;
    logic [AW-1:0] pop_rd_addr_o;
    logic [DW-1:0] pop_rd_data_i = '0;
    logic [NP-1:0] par_wr_en_o;
    logic [EW-1:0] par_wr_addr_o;
    logic [DW-1:0] par_wr_data_o;
    logic          busy_o;
    logic          done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    parent_fetch_seq #(.NUM_PAR(NP), .NUM_ELEM(NE), .IDX_W(IW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .idx_i(idx_i),
        .pop_rd_en_o(pop_rd_en_o), .pop_rd_addr_o(pop_rd_addr_o),
        .pop_rd_data_i(pop_rd_data_i), .par_wr_en_o(par_wr_en_o),
        .par_wr_addr_o(par_wr_addr_o), .par_wr_data_o(par_wr_data_o),
        .busy_o(busy_o), .done_o(done_o));

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return (32'(a) * 32'h9E3779B1) ^ 32'h13579BDF;
    endfunction

    // Population memory model with synchronous read
    always @(posedge clk) if (pop_rd_en_o) pop_rd_data_i <= pat(pop_rd_addr_o);

    // Parent memory model plus write bookkeeping
    logic [DW-1:0] pmem [NP][NE];
    int            ptag [NP][NE];
    int            run_id = 0;
    int            wr_total = 0;
    always @(posedge clk) begin
        for (int p = 0; p < NP; p++) begin
            if (par_wr_en_o[p]) begin
                pmem[p][par_wr_addr_o] <= par_wr_data_o;
                ptag[p][par_wr_addr_o] <= run_id;
            end
        end
        if (|par_wr_en_o) wr_total <= wr_total + 1;
    end

    // Read-order monitor
    logic [NP*IW-1:0] cur_flat = '0;
    int rd_total = 0;
    int rd_base = 0;
    int addr_bad = 0;
    int hot_bad = 0;
    always @(negedge clk) begin
        if ($countones(par_wr_en_o) > 1) hot_bad <= hot_bad + 1;
        if (pop_rd_en_o) begin
            int ptr;
            int p;
            int e;
            ptr = rd_total - rd_base;
            p = ptr / NE;
            e = ptr % NE;
            if (ptr >= T || pop_rd_addr_o != {cur_flat[p*IW +: IW], EW'(e)})
                addr_bad <= addr_bad + 1;
            rd_total <= rd_total + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_copy(input logic [NP*IW-1:0] sel, input bit disturb);
        int n;
        int wr0;
        int ab0;
        int bad;
        run_id++;
        cur_flat = sel;
        idx_i = sel;
        rd_base = rd_total;
        wr0 = wr_total;
        ab0 = addr_bad;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        n = 1;
        while (!done_o && n < 100) begin
            if (disturb && n == 3) begin
                idx_i = ~sel;
                start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start_i = 1'b0;
        // R7, R8: done timing unaffected by a start during the copy
        check(n == T + 2, disturb ? "R8 cycles to done" : "R7 cycles to done", n, T + 2);
        @(negedge clk);
        check(!done_o && !busy_o, "R7 done single cycle", int'(done_o), 0);
        // R2, R3, R4: read count and order
        check(wr_total - wr0 == T, "R2 read/write count", wr_total - wr0, T);
        check(addr_bad == ab0, "R3 R4 address sequence", addr_bad - ab0, 0);
        check(hot_bad == 0, "R5 single strobe", hot_bad, 0);
        // R5, R6, R9: parent memory contents
        bad = 0;
        for (int p = 0; p < NP; p++)
            for (int e = 0; e < NE; e++)
                if (ptag[p][e] != run_id || pmem[p][e] != pat({sel[p*IW +: IW], EW'(e)}))
                    bad++;
        check(bad == 0, disturb ? "R6 contents with idx change" : "R5 R9 contents", bad, 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !pop_rd_en_o && par_wr_en_o == '0,
              "R1 state in reset", int'(busy_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && !pop_rd_en_o && par_wr_en_o == '0,
              "R1 idle after reset", int'(pop_rd_en_o), 0);
        run_copy({5'd3, 5'd2, 5'd1, 5'd0}, 1'b0);
        run_copy({5'd31, 5'd0, 5'd31, 5'd0}, 1'b0);
        run_copy({5'd7, 5'd7, 5'd7, 5'd7}, 1'b0);   // R9 repeated individuals
        run_copy({5'd9, 5'd22, 5'd14, 5'd30}, 1'b1);
        for (int r = 0; r < 6; r++) begin
            logic [NP*IW-1:0] s;
            for (int p = 0; p < NP; p++) s[p*IW +: IW] = IW'($urandom);
            run_copy(s, r[0]);
        end
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule